// File: doc/BRIEF.md
# Dual-Mode Character Write Controller

This block is the host-facing write side of an eight-character display driver. It stores eight 6-bit character codes and offers a combinational read port that the display scan logic uses. A host writes a character by pulsing a combined write strobe. That strobe is active only while the active-low write input, the active-low select and the active-high select are all asserted. The block runs from a fast system clock. It synchronises the combined strobe and acts on the edges it detects.

Each transaction latches a mode bit at the strobe's start. In random mode the transaction also latches a 3-bit slot address, so address and data may share one host bus. In sequential mode an internal slot counter supplies the address, and the host uses the same pins for other jobs: bit 0 carries a serial enable and bit 1 carries an active-low clear. A full flag marks the point at which all eight slots have been filled. That flag lets several drivers sit on one bus and fill in turn.

The shared pins are modelled as a separate address input, a full output and an output enable for that full output.

Top module: `dispwr_ctrl`

## Requirements
- R1: A write occurs only when wr_n=0, cs_n=0 and cs_en=1 all hold together. A pulse in which any one of the three is inactive changes no slot.
- R2: mode_in is captured only at the start of the combined strobe, where 0 means random and 1 means sequential. A change of mode_in during the strobe has no effect on that transaction or on full_oe.
- R3: In random mode, addr_in is captured at the start of the strobe. The data goes to that slot even when addr_in changes before the strobe ends.
- R4: Write data is taken at the end of the strobe. A change of data_in while the strobe is active stores the later value.
- R5: In sequential mode with the serial enable (addr_in[0] latched at the strobe's start) high, successive writes fill slots 0,1,...,7 in order.
- R6: In sequential mode with the latched serial enable low, a write changes no slot and does not advance the counter.
- R7: full_out goes to 1 after the write to slot 7. While it is set, further sequential writes change nothing.
- R8: While sequential mode is latched, addr_in[1]=0 clears at once, without waiting for a clock edge. The clear sets every slot to 6'b100000, sets the counter to slot 0 and sets full to 0. In random mode addr_in[1]=0 has no effect.
- R9: full_oe is 1 exactly while sequential mode is latched. full_out reads 0 whenever full_oe is 0.
- R10: After reset every slot holds 6'b100000, random mode is latched and full_out and full_oe are 0.
- R11: rd_data shows the code stored at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write |
| cs_n | input | 1 | Active-low select |
| cs_en | input | 1 | Active-high select |
| mode_in | input | 1 | 0 random, 1 sequential; latched at strobe start |
| addr_in | input | 3 | Slot address (random); bit0 serial enable, bit1 clear_n (sequential) |
| data_in | input | 6 | Character code |
| rd_addr | input | 3 | Scan read address |
| rd_data | output | 6 | Code at rd_addr |
| full_out | output | 1 | Sequential fill complete |
| full_oe | output | 1 | Output enable of full_out |

## Verification
All eight combinations of the three strobe inputs are applied, and only the fully enabled one may alter a slot; this separates a correct AND from a missing or inverted term. Every slot is then written in random mode with distinct codes and read back, which exposes address decoding faults. Mode, address and data are changed in the middle of a strobe, which shows whether each is captured at the correct edge. A sequential fill runs past slot 7 and is then cleared, repeated with the enable low, and followed by a clear attempt in random mode. These runs tell apart the ordering, the full blocking, the enable gating and the mode qualification of the clear.

// File: rtl/dispwr_pkg.sv
package dispwr_pkg;
    localparam int unsigned CHARS  = 8;
    localparam int unsigned CODE_W = 6;
    localparam int unsigned ADDR_W = $clog2(CHARS);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam code_t BLANK_CODE = code_t'(1 << (CODE_W - 1));
    localparam addr_t LAST_SLOT  = addr_t'(CHARS - 1);

    typedef enum logic {
        WM_RANDOM = 1'b0,
        WM_SEQ    = 1'b1
    } wmode_e;

    typedef struct packed {
        wmode_e mode;
        addr_t  addr;
        logic   sen;
    } cmd_t;

    function automatic addr_t next_slot(addr_t a);
        return (a == LAST_SLOT) ? '0 : a + addr_t'(1);
    endfunction
endpackage

// File: rtl/dw_strobe_sync.sv
module dw_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    input  logic cs_n,
    input  logic cs_en,
    output logic start_p,
    output logic end_p
);
    logic              raw;
    logic [STAGES-1:0] sh;
    logic              last;

    assign raw = ~wr_n & ~cs_n & cs_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            last <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], raw};
            last <= sh[STAGES-1];
        end
    end

    assign start_p = sh[STAGES-1] & ~last;
    assign end_p   = ~sh[STAGES-1] & last;
endmodule

// File: rtl/dw_cmd_latch.sv
module dw_cmd_latch
    import dispwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_p,
    input  logic  mode_in,
    input  addr_t addr_in,
    output cmd_t  cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd.mode <= WM_RANDOM;
            cmd.addr <= '0;
            cmd.sen  <= 1'b0;
        end else if (start_p) begin
            cmd.mode <= wmode_e'(mode_in);
            if (mode_in) cmd.sen  <= addr_in[0];
            else         cmd.addr <= addr_in;
        end
    end
endmodule

// File: rtl/dw_seq_ctr.sv
module dw_seq_ctr
    import dispwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_a,
    input  logic  end_p,
    input  cmd_t  cmd,
    output addr_t slot,
    output logic  full,
    output logic  seq_wr
);
    assign seq_wr = end_p & (cmd.mode == WM_SEQ) & cmd.sen & ~full;

    always_ff @(posedge clk or posedge clr_a) begin
        if (clr_a) begin
            slot <= '0;
            full <= 1'b0;
        end else if (rst) begin
            slot <= '0;
            full <= 1'b0;
        end else if (seq_wr) begin
            slot <= next_slot(slot);
            if (slot == LAST_SLOT) full <= 1'b1;
        end
    end
endmodule

// File: rtl/dw_char_mem.sv
module dw_char_mem
    import dispwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_a,
    input  logic  we,
    input  addr_t waddr,
    input  code_t wdata,
    input  addr_t raddr,
    output code_t rdata
);
    code_t mem [CHARS];

    for (genvar g = 0; g < CHARS; g++) begin : g_slot
        always_ff @(posedge clk or posedge clr_a) begin
            if (clr_a)                           mem[g] <= BLANK_CODE;
            else if (rst)                        mem[g] <= BLANK_CODE;
            else if (we && waddr == addr_t'(g))  mem[g] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dispwr_ctrl.sv
module dispwr_ctrl
    import dispwr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_n,
    input  logic        cs_n,
    input  logic        cs_en,
    input  logic        mode_in,
    input  logic [2:0]  addr_in,
    input  logic [5:0]  data_in,
    input  logic [2:0]  rd_addr,
    output logic [5:0]  rd_data,
    output logic        full_out,
    output logic        full_oe
);
    logic  start_p, end_p;
    cmd_t  cmd;
    addr_t slot;
    logic  seq_full, seq_wr, rnd_wr, we, clr_a, mode_seq;
    addr_t waddr;

    dw_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .cs_en(cs_en),
        .start_p(start_p), .end_p(end_p)
    );

    dw_cmd_latch u_cmd (
        .clk(clk), .rst(rst), .start_p(start_p), .mode_in(mode_in),
        .addr_in(addr_in), .cmd(cmd)
    );

    assign mode_seq = (cmd.mode == WM_SEQ);
    assign clr_a    = mode_seq & ~addr_in[1];

    dw_seq_ctr u_ctr (
        .clk(clk), .rst(rst), .clr_a(clr_a), .end_p(end_p), .cmd(cmd),
        .slot(slot), .full(seq_full), .seq_wr(seq_wr)
    );

    assign rnd_wr = end_p & ~mode_seq;
    assign we     = rnd_wr | seq_wr;
    assign waddr  = mode_seq ? slot : cmd.addr;

    dw_char_mem u_mem (
        .clk(clk), .rst(rst), .clr_a(clr_a), .we(we), .waddr(waddr),
        .wdata(data_in), .raddr(rd_addr), .rdata(rd_data)
    );

    assign full_oe  = mode_seq;
    assign full_out = seq_full & mode_seq;
endmodule

// File: rtl/dispwr_ctrl_chk.sv
module dispwr_ctrl_chk
    import dispwr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  clr_a,
    input logic  start_p,
    input logic  end_p,
    input logic  mode_seq,
    input addr_t slot,
    input logic  seq_full,
    input logic  full_out,
    input logic  full_oe
);
    // R2: latched mode moves only at a strobe start
    p_mode_at_start_r2: assert property (@(posedge clk) disable iff (rst)
        !start_p |=> $stable(mode_seq));

    // R5: counter advances only on a strobe end
    p_slot_on_end_r5: assert property (@(posedge clk) disable iff (rst || clr_a)
        !end_p |=> $stable(slot));

    // R7: full holds and freezes the counter until a clear
    p_full_sticky_r7: assert property (@(posedge clk) disable iff (rst || clr_a)
        seq_full |=> seq_full && $stable(slot));

    // R8: an active clear holds counter and full at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr_a |-> (slot == '0) && !seq_full);

    // R9: full is driven only with its enable
    p_full_gated_r9: assert property (@(posedge clk) disable iff (rst)
        full_out |-> full_oe);
endmodule

bind dispwr_ctrl dispwr_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .clr_a(clr_a), .start_p(start_p), .end_p(end_p),
    .mode_seq(mode_seq), .slot(slot), .seq_full(seq_full),
    .full_out(full_out), .full_oe(full_oe)
);

// File: tb/tb_dispwr_ctrl.sv
`timescale 1ns/1ps
module tb_dispwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] BLANK = 6'b100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, cs_n = 1'b1, cs_en = 1'b0, mode_in = 1'b0;
    logic [2:0] addr_in = 3'b010;
    logic [5:0] data_in = '0;
    logic [2:0] rd_addr = '0;
    logic [5:0] rd_data;
    logic       full_out, full_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [5:0] shadow [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dispwr_ctrl dut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .cs_en(cs_en),
        .mode_in(mode_in), .addr_in(addr_in), .data_in(data_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .full_out(full_out), .full_oe(full_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            check(req, int'(rd_data), int'(shadow[a]));
        end
    endtask

    // One strobe; optional mid-strobe changes of mode, address and data.
    task automatic strobe(input logic wn, input logic csn, input logic cse,
                          input logic md, input logic [2:0] a, input logic [5:0] d,
                          input bit mid, input logic md2, input logic [2:0] a2,
                          input logic [5:0] d2);
        @(negedge clk);
        mode_in = md; addr_in = a; data_in = d;
        wr_n = wn; cs_n = csn; cs_en = cse;
        repeat (3) @(negedge clk);
        if (mid) begin mode_in = md2; addr_in = a2; data_in = d2; end
        repeat (2) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; cs_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr_rnd(input logic [2:0] a, input logic [5:0] d);
        strobe(0, 0, 1, 0, a, d, 0, 0, 0, 0);
        shadow[a] = d;
    endtask

    task automatic wr_seq(input logic sen, input logic [5:0] d);
        strobe(0, 0, 1, 1, {2'b01, sen}, d, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) shadow[i] = BLANK;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check_mem("R10");
        check("R10 oe", int'(full_oe), 0);
        check("R10 full", int'(full_out), 0);

        // R1 every strobe-input combination onto slot 5
        for (int c = 0; c < 8; c++) begin
            strobe(c[2], c[1], c[0], 0, 3'd5, 6'(10 + c), 0, 0, 0, 0);
            if (c == 1) shadow[5] = 6'(10 + c);
            rd_addr = 3'd5; #1;
            check("R1", int'(rd_data), int'(shadow[5]));
        end

        // R11 / R3 exhaustive random fill
        for (int a = 0; a < 8; a++) wr_rnd(3'(a), 6'((a * 7 + 1) & 63));
        check_mem("R11");

        // R3 address moves mid-strobe
        strobe(0, 0, 1, 0, 3'd1, 6'h2A, 1, 0, 3'd6, 6'h2A);
        shadow[1] = 6'h2A;
        check_mem("R3");

        // R4 data moves mid-strobe
        strobe(0, 0, 1, 0, 3'd2, 6'h11, 1, 0, 3'd2, 6'h22);
        shadow[2] = 6'h22;
        check_mem("R4");

        // R9 enter sequential mode with enable low
        wr_seq(0, 6'h3F);
        check("R9 oe", int'(full_oe), 1);
        check("R9 full", int'(full_out), 0);
        check_mem("R6 sen low");

        // R8 asynchronous clear
        @(negedge clk); #2;
        addr_in = 3'b000; #1;
        for (int i = 0; i < 8; i++) shadow[i] = BLANK;
        check_mem("R8 clear");
        @(negedge clk); addr_in = 3'b010;

        // R2 mode_in drops mid-strobe: still sequential
        strobe(0, 0, 1, 1, 3'b011, 6'd5, 1, 0, 3'b011, 6'd5);
        shadow[0] = 6'd5;
        check("R2 oe", int'(full_oe), 1);
        check_mem("R2");

        // R5 fill remaining slots in order, R7 full after slot 7
        for (int i = 1; i < 8; i++) begin
            wr_seq(1, 6'(20 + i));
            shadow[i] = 6'(20 + i);
            rd_addr = 3'(i); #1;
            check("R5", int'(rd_data), 20 + i);
            check("R7 full", int'(full_out), (i == 7) ? 1 : 0);
        end
        wr_seq(1, 6'd63);
        check_mem("R7 blocked");
        check("R7 held", int'(full_out), 1);

        // R6 enable low after clear leaves counter at slot 0
        @(negedge clk); addr_in = 3'b000;
        @(negedge clk); addr_in = 3'b010;
        for (int i = 0; i < 8; i++) shadow[i] = BLANK;
        check("R8 full", int'(full_out), 0);
        wr_seq(0, 6'd9);
        check_mem("R6");
        wr_seq(1, 6'd9);
        shadow[0] = 6'd9;
        check_mem("R6 slot0");

        // R9 back to random
        wr_rnd(3'b010, 6'd7);
        check("R9 oe off", int'(full_oe), 0);
        check("R9 full off", int'(full_out), 0);

        // R8 clear pin ignored in random mode
        @(negedge clk); addr_in = 3'b000;
        repeat (5) @(negedge clk);
        check_mem("R8 random");
        addr_in = 3'b010;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule